// File: doc/BRIEF.md
# Instruction List Sequencer

This block runs a stored list of bus-transfer instructions with no processor help. A host writes 32-bit entries into a circular list memory and then pulses an execute strobe. From then on the sequencer fetches one entry at a time. Bus-operation entries go to a separate bus-cycle engine over a request/done handshake. Control entries either wait for an external trigger or jump back to the first entry. A readout loop of the form "wait for trigger, read modules, start again" therefore runs for as long as needed.

The two top bits of each entry select its kind. For a bus operation, the next two bits give the word period of a pipelined transfer. The engine receives the whole entry unchanged. An abort strobe stops the sequencer at once and empties the list, so that a new list can be loaded. A busy flag and a latched error flag make up the status.

Top module: `list_seq`

## Requirements
- R1: While the sequencer is idle, each host write appends its word at the next list position, from position 0 up to DEPTH (64) entries. A write while busy, or when the list is full, is ignored.
- R2: An execute strobe while idle starts execution at list position 0. It raises busy_o on the following clock edge and clears err_o. An execute strobe while busy is ignored and does not restart the list.
- R3: Entry bits [31:30] hold the kind: 00 bus operation, 01 wait for trigger, 10 re-execute, 11 end of list. Bus operations are issued in list order, one at a time. eng_cmd_o carries the full entry, and eng_req_o stays high with eng_cmd_o stable until eng_done_i is seen.
- R4: In a bus operation, bits [29:28] select the word period: 0 = 100 ns, 1 = 200 ns, 2 = 400 ns. Code 3 is illegal. An entry with code 3 is not issued; it sets err_o and ends execution.
- R5: A wait-for-trigger entry stalls the sequencer until a trigger is seen. Execution then continues with the next entry.
- R6: A trigger that arrives while the sequencer is not waiting is held in one pending flag. A later wait entry consumes it without stalling. Any further triggers beyond that one are not remembered.
- R7: A re-execute entry moves the read position back to list position 0, and execution continues from there.
- R8: An end-of-list entry, or reaching the position after the last written entry, returns the sequencer to idle with busy_o low. An empty list ends at once and issues no request.
- R9: If eng_err_i is high together with eng_done_i, err_o latches high, busy_o falls, and no further request is made.
- R10: abort_i has priority over everything else. On the next edge, busy_o and eng_req_o are low, the list is empty and any pending trigger is dropped.
- R11: After reset, busy_o, err_o and eng_req_o are low and the list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_wr_i | input | 1 | Host write strobe for the list |
| list_data_i | input | 32 | Host list entry |
| exec_i | input | 1 | Execute strobe |
| abort_i | input | 1 | Abort strobe |
| trig_i | input | 1 | External trigger, one-cycle pulse |
| eng_req_o | output | 1 | Request to the bus-cycle engine |
| eng_cmd_o | output | 32 | Entry being issued to the engine |
| eng_done_i | input | 1 | Engine completion |
| eng_err_i | input | 1 | Engine error, valid with eng_done_i |
| busy_o | output | 1 | Sequencer running |
| err_o | output | 1 | Latched error flag |

## Verification
Two events can fall in the same cycle: a trigger arriving and the sequencer consuming one, whether a pending one or a live one. The bench sends two triggers while the sequencer is idle and then runs a list with two wait entries. Only the first wait may pass without a new trigger. The second case is an abort landing while a request is outstanding or a fetch is under way. The bench aborts in the middle of an endless re-execute loop and requires request and busy to be low one edge later. It also requires the commands issued before the abort to follow the list order exactly.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [1:0] {
    OP_BUS  = 2'b00,
    OP_WAIT = 2'b01,
    OP_LOOP = 2'b10,
    OP_END  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_REQ,
    S_TRIG
  } st_e;

  localparam logic [1:0] RATE_BAD = 2'b11;
endpackage

// File: rtl/lseq_ram.sv
module lseq_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/lseq_trig.sv
module lseq_trig (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic trig_i,
  input  logic take_i,
  output logic seen_o
);
  logic pend_q;

  assign seen_o = pend_q | trig_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  pend_q <= 1'b0;
    else if (take_i)   pend_q <= 1'b0;
    else if (trig_i)   pend_q <= 1'b1;
  end
endmodule

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             exec_i,
  input  logic             abort_i,
  input  logic [WIDTH-1:0] entry_i,
  input  logic             trig_seen_i,
  input  logic             eng_done_i,
  input  logic             eng_err_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_waddr_o,
  output logic [AW-1:0]    mem_raddr_o,
  output logic             trig_take_o,
  output logic             eng_req_o,
  output logic [WIDTH-1:0] eng_cmd_o,
  output logic             busy_o,
  output logic             err_o
);
  st_e           state;
  logic [AW:0]   wr_cnt;
  logic [AW:0]   rd_ptr;
  op_e           op;
  logic [1:0]    rate;
  logic          full;

  assign op          = op_e'(entry_i[WIDTH-1 -: 2]);
  assign rate        = entry_i[WIDTH-3 -: 2];
  assign full        = (wr_cnt == (AW+1)'(DEPTH));
  assign mem_we_o    = wr_i && !abort_i && (state == S_IDLE) && !full;
  assign mem_waddr_o = wr_cnt[AW-1:0];
  assign mem_raddr_o = rd_ptr[AW-1:0];
  assign trig_take_o = (state == S_TRIG) && trig_seen_i && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      wr_cnt    <= '0;
      rd_ptr    <= '0;
      eng_req_o <= 1'b0;
      eng_cmd_o <= '0;
      busy_o    <= 1'b0;
      err_o     <= 1'b0;
    end else if (abort_i) begin
      state     <= S_IDLE;
      wr_cnt    <= '0;
      rd_ptr    <= '0;
      eng_req_o <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      if (mem_we_o) wr_cnt <= wr_cnt + 1'b1;
      unique case (state)
        S_IDLE: begin
          if (exec_i) begin
            rd_ptr <= '0;
            busy_o <= 1'b1;
            err_o  <= 1'b0;
            state  <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (rd_ptr == wr_cnt) begin
            busy_o <= 1'b0;
            state  <= S_IDLE;
          end else begin
            state  <= S_DECODE;
          end
        end
        S_DECODE: begin
          unique case (op)
            OP_BUS: begin
              if (rate == RATE_BAD) begin
                err_o  <= 1'b1;
                busy_o <= 1'b0;
                state  <= S_IDLE;
              end else begin
                eng_req_o <= 1'b1;
                eng_cmd_o <= entry_i;
                state     <= S_REQ;
              end
            end
            OP_WAIT: state <= S_TRIG;
            OP_LOOP: begin
              rd_ptr <= '0;
              state  <= S_FETCH;
            end
            OP_END: begin
              busy_o <= 1'b0;
              state  <= S_IDLE;
            end
          endcase
        end
        S_REQ: begin
          if (eng_done_i) begin
            eng_req_o <= 1'b0;
            if (eng_err_i) begin
              err_o  <= 1'b1;
              busy_o <= 1'b0;
              state  <= S_IDLE;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
              state  <= S_FETCH;
            end
          end
        end
        S_TRIG: begin
          if (trig_seen_i) begin
            rd_ptr <= rd_ptr + 1'b1;
            state  <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/list_seq.sv
module list_seq #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             list_wr_i,
  input  logic [WIDTH-1:0] list_data_i,
  input  logic             exec_i,
  input  logic             abort_i,
  input  logic             trig_i,
  output logic             eng_req_o,
  output logic [WIDTH-1:0] eng_cmd_o,
  input  logic             eng_done_i,
  input  logic             eng_err_i,
  output logic             busy_o,
  output logic             err_o
);
  localparam int AW = $clog2(DEPTH);

  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [AW-1:0]    mem_raddr;
  logic [WIDTH-1:0] mem_rdata;
  logic             trig_seen;
  logic             trig_take;

  lseq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ram_i (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (list_data_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  lseq_trig trig_i0 (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (abort_i),
    .trig_i (trig_i),
    .take_i (trig_take),
    .seen_o (trig_seen)
  );

  lseq_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (list_wr_i),
    .exec_i      (exec_i),
    .abort_i     (abort_i),
    .entry_i     (mem_rdata),
    .trig_seen_i (trig_seen),
    .eng_done_i  (eng_done_i),
    .eng_err_i   (eng_err_i),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_raddr_o (mem_raddr),
    .trig_take_o (trig_take),
    .eng_req_o   (eng_req_o),
    .eng_cmd_o   (eng_cmd_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/lseq_chk.sv
module lseq_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             exec_i,
  input logic             abort_i,
  input logic             eng_req_o,
  input logic [WIDTH-1:0] eng_cmd_o,
  input logic             eng_done_i,
  input logic             eng_err_i,
  input logic             busy_o,
  input logic             err_o
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    eng_req_o && !eng_done_i && !abort_i |=> eng_req_o && $stable(eng_cmd_o));

  p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> busy_o);

  p_bus_only_r4: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> (eng_cmd_o[WIDTH-1 -: 2] == 2'b00) && (eng_cmd_o[WIDTH-3 -: 2] != 2'b11));

  p_exec_start_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o && exec_i && !abort_i |=> busy_o && !err_o);

  p_err_stop_r9: assert property (@(posedge clk) disable iff (rst)
    eng_req_o && eng_done_i && eng_err_i && !abort_i |=> err_o && !busy_o && !eng_req_o);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o && !eng_req_o);
endmodule

bind list_seq lseq_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .exec_i     (exec_i),
  .abort_i    (abort_i),
  .eng_req_o  (eng_req_o),
  .eng_cmd_o  (eng_cmd_o),
  .eng_done_i (eng_done_i),
  .eng_err_i  (eng_err_i),
  .busy_o     (busy_o),
  .err_o      (err_o)
);

// File: tb/list_seq_tb_top.sv
module list_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        list_wr = 1'b0;
  logic [31:0] list_data = '0;
  logic        exec = 1'b0;
  logic        abort = 1'b0;
  logic        trig = 1'b0;
  logic        eng_req;
  logic [31:0] eng_cmd;
  logic        eng_done = 1'b0;
  logic        eng_err = 1'b0;
  logic        busy;
  logic        err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] got [256];
  int got_n = 0;
  int err_at = -1;

  always #10 clk = ~clk;

  list_seq dut_i (
    .clk(clk), .rst(rst), .list_wr_i(list_wr), .list_data_i(list_data),
    .exec_i(exec), .abort_i(abort), .trig_i(trig),
    .eng_req_o(eng_req), .eng_cmd_o(eng_cmd),
    .eng_done_i(eng_done), .eng_err_i(eng_err),
    .busy_o(busy), .err_o(err)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // engine model: answers each request with a one-cycle done
  initial begin
    forever begin
      @(negedge clk);
      if (eng_done) begin
        eng_done = 1'b0;
        eng_err  = 1'b0;
      end else if (eng_req) begin
        if (got_n < 256) got[got_n] = eng_cmd;
        eng_err  = (got_n == err_at);
        got_n    = got_n + 1;
        eng_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bus(input int rate, input int pay);
    return {2'b00, rate[1:0], pay[27:0]};
  endfunction
  localparam logic [31:0] E_WAIT = 32'h4000_0000;
  localparam logic [31:0] E_LOOP = 32'h8000_0000;
  localparam logic [31:0] E_END  = 32'hC000_0000;

  task automatic wr(input logic [31:0] w);
    list_wr = 1'b1; list_data = w;
    @(negedge clk);
    list_wr = 1'b0;
  endtask
  task automatic pulse_exec();
    exec = 1'b1; @(negedge clk); exec = 1'b0;
  endtask
  task automatic pulse_trig();
    trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask
  task automatic do_abort();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (2) @(negedge clk);
    got_n = 0;
    err_at = -1;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask
  task automatic wait_got(input int n);
    for (int i = 0; i < 2000 && got_n < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !err && !eng_req, "R11 reset outputs", {busy, err, eng_req}, 0);

    // R8 empty list: busy for a moment, no request
    pulse_exec();
    chk(busy, "R2 busy after execute", busy, 1);
    wait_idle();
    chk(got_n == 0 && !busy, "R8 empty list issues nothing", got_n, 0);

    // R1 R3 R4 full list sweep over all legal rates, extra write ignored
    for (int i = 0; i < 64; i++) wr(bus(i % 3, i * 7 + 1));
    wr(E_END);
    pulse_exec();
    wait_idle();
    chk(got_n == 64, "R1 full list command count", got_n, 64);
    for (int i = 0; i < 64; i++)
      chk(got[i] == bus(i % 3, i * 7 + 1), "R3 R4 command order and rate", got[i], bus(i % 3, i * 7 + 1));
    chk(!err, "R4 legal rates raise no error", err, 0);
    do_abort();

    // R8 end entry stops before later entries
    wr(bus(1, 11)); wr(E_END); wr(bus(2, 12));
    pulse_exec();
    wait_idle();
    chk(got_n == 1 && got[0] == bus(1, 11), "R8 end entry stops list", got_n, 1);
    do_abort();

    // R4 illegal rate halts with error
    wr(bus(0, 21)); wr(bus(3, 22)); wr(bus(0, 23)); wr(E_END);
    pulse_exec();
    wait_idle();
    chk(got_n == 1, "R4 illegal rate not issued", got_n, 1);
    chk(err && !busy, "R4 illegal rate sets error", {err, busy}, 2);
    do_abort();

    // R9 engine error stops, R2 execute clears error
    wr(bus(0, 31)); wr(bus(1, 32)); wr(bus(2, 33)); wr(E_END);
    err_at = 1;
    pulse_exec();
    wait_idle();
    chk(got_n == 2, "R9 no request after engine error", got_n, 2);
    chk(err, "R9 error latched", err, 1);
    err_at = -1; got_n = 0;
    pulse_exec();
    chk(!err && busy, "R2 execute clears error", {err, busy}, 1);
    wait_idle();
    chk(got_n == 3 && got[2] == bus(2, 33), "R2 rerun full list", got_n, 3);
    do_abort();

    // R5 wait for trigger; R1 write while busy and R2 execute while busy ignored
    wr(bus(0, 41)); wr(E_WAIT); wr(bus(1, 42));
    pulse_exec();
    wait_got(1);
    repeat (20) @(negedge clk);
    chk(got_n == 1 && busy, "R5 stalled awaiting trigger", got_n, 1);
    wr(bus(2, 43));
    pulse_exec();
    repeat (5) @(negedge clk);
    chk(got_n == 1, "R2 execute while busy ignored", got_n, 1);
    pulse_trig();
    wait_idle();
    chk(got_n == 2 && got[1] == bus(1, 42), "R5 resumes with next entry", got_n, 2);
    chk(got_n == 2, "R1 write while busy ignored", got_n, 2);
    do_abort();

    // R6 one pending trigger remembered
    pulse_trig(); @(negedge clk); pulse_trig();
    wr(E_WAIT); wr(bus(0, 51)); wr(E_WAIT); wr(bus(1, 52)); wr(E_END);
    pulse_exec();
    repeat (30) @(negedge clk);
    chk(got_n == 1 && got[0] == bus(0, 51) && busy, "R6 single pending trigger", got_n, 1);
    pulse_trig();
    wait_idle();
    chk(got_n == 2 && got[1] == bus(1, 52), "R6 second wait needs new trigger", got_n, 2);
    do_abort();

    // R10 abort drops pending trigger
    pulse_trig();
    do_abort();
    wr(E_WAIT); wr(bus(0, 61)); wr(E_END);
    pulse_exec();
    repeat (20) @(negedge clk);
    chk(got_n == 0 && busy, "R10 abort clears pending trigger", got_n, 0);
    do_abort();

    // R7 re-execute loop, R10 abort in flight
    wr(bus(0, 71)); wr(bus(2, 72)); wr(E_LOOP);
    pulse_exec();
    wait_got(5);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!busy && !eng_req, "R10 abort stops at once", {busy, eng_req}, 0);
    for (int i = 0; i < 5; i++)
      chk(got[i] == ((i % 2 == 0) ? bus(0, 71) : bus(2, 72)), "R7 replay from first entry",
          got[i], (i % 2 == 0) ? bus(0, 71) : bus(2, 72));
    repeat (3) @(negedge clk);
    got_n = 0;
    pulse_exec();
    wait_idle();
    chk(got_n == 0, "R10 abort empties list", got_n, 0);

    summary();
  end
endmodule